// File: doc/BRIEF.md
# Disk Drive Start/Stop Sequencer

This block owns the run state of a removable-cartridge disk drive and walks the drive through its start sequence. A debounced run/stop pushbutton strobe acts as a guarded toggle. A press while the drive runs always stops it. A press while the drive is stopped starts it only when the heads are retracted, the platter is still, no brake cycle is active, and the previous stop has fully finished. Removing the cartridge, an emergency unload or a power clear forces the run state off at any time.

When run is set, the sequencer first enters a purge phase. During purge it asks for a spindle speed ten percent above nominal, to raise the airflow over the platters. It then loads the heads and finally raises sequence-complete. External one-cycle done strobes advance each phase. A drop of run raises a stop-pending flag. Sequence-complete, if it was reached, stays up as the marker of a stop in progress. Both clear only when the stop logic reports completion with the heads retracted. Until then no restart is accepted.

Top module: `dss_startstop`

## Requirements
- R1: An active `rst_ni` (asynchronous) or an asserted `pwr_clr_i` (sampled at a clock edge) puts every state element into the stopped state. After that edge run, purge, load-heads, sequence-complete, stop-pending and overspeed are 0, `speed_pct_o` is 0, and the switch synchronisers hold "not inserted".
- R2: A button strobe seen while run is 1 clears run at that edge, whatever the interlock inputs are.
- R3: A button strobe seen while run is 0 sets run at that edge only if `heads_retracted_i`=1, `disk_rotating_i`=0 and `brake_active_i`=0. Otherwise run stays 0.
- R4: Cartridge-correct is the AND of the two switch levels after a two-stage synchroniser each. A switch change therefore reaches run control at the second edge and affects run at the third. With `front_load_i`=1, switch B is ignored and treated as inserted. While cartridge-correct is 0, run is forced to 0 and no press can set it.
- R5: `emerg_unload_i`=1 forces run to 0 at the edge, and blocks a set, without resetting the other state.
- R6: The start order is fixed. Run rises at edge k. Purge rises at edge k+1. `purge_done_i` during purge moves to load-heads. `load_done_i` during load-heads moves to ready and sets sequence-complete. At most one of purge and load-heads is 1.
- R7: `overspeed_o` is 1 exactly during purge. `speed_pct_o` is 110 during purge, 100 while run is 1 outside purge, and 0 while run is 0.
- R8: When run falls for any reason other than power clear, stop-pending rises at the same edge and purge and load-heads drop at that edge.
- R9: Run cannot be set while stop-pending or sequence-complete is 1. `stop_done_i` with `heads_retracted_i`=1 clears both flags. `stop_done_i` with the heads not retracted leaves them unchanged.
- R10: A done strobe outside its own phase has no effect: `purge_done_i` only acts during purge, and `load_done_i` only acts during load-heads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_clr_i | input | 1 | Power clear, synchronous clear to stopped state |
| emerg_unload_i | input | 1 | Emergency unload, forces run off |
| run_btn_i | input | 1 | Debounced run/stop button, one-cycle strobe |
| cart_sw_a_i | input | 1 | Cartridge switch A level, 1 = inserted |
| cart_sw_b_i | input | 1 | Cartridge switch B level, 1 = inserted |
| front_load_i | input | 1 | Model strap, 1 = single-switch front-load variant |
| heads_retracted_i | input | 1 | Heads are retracted |
| disk_rotating_i | input | 1 | Platter is rotating |
| brake_active_i | input | 1 | Brake cycle in progress |
| purge_done_i | input | 1 | Purge time elapsed strobe |
| load_done_i | input | 1 | Heads loaded strobe |
| stop_done_i | input | 1 | Stop sequence finished strobe |
| run_o | output | 1 | Run state |
| purge_o | output | 1 | Purge phase active |
| load_heads_o | output | 1 | Head-load phase active |
| seq_done_o | output | 1 | Sequence complete / stop marker |
| stop_pend_o | output | 1 | Stop in progress, restart blocked |
| overspeed_o | output | 1 | Spindle overspeed request |
| speed_pct_o | output | 8 | Requested spindle speed, percent of nominal |

## Verification
The bench goes after restart attempts between the drop of run and stop completion. A design that keyed the restart block on run alone would spin the drive up again with the heads still out. Each start interlock is held bad in turn across a press. A missing term would show up as run rising at that press. The bench also drops a cartridge switch during run, with and without the front-load strap, and checks the exact edge at which run falls. A wrong synchroniser depth, or a strap that masks the wrong switch, would shift that edge or leave run set. Done strobes arrive out of phase and coincide with presses and emergency unloads. A sequencer that advanced on a stray strobe, or that kept purge or load-heads after run fell, would break the phase order or the speed request.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PURGE = 2'd1,
    PH_LOAD  = 2'd2,
    PH_READY = 2'd3
  } phase_e;
endpackage

// File: rtl/dss_cart_latch.sv
module dss_cart_latch #(
  parameter int unsigned N_SW   = 2,
  parameter int unsigned SYNC_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_clr_i,
  input  logic [N_SW-1:0] sw_i,
  input  logic            front_load_i,
  output logic            cart_ok_o
);
  logic [N_SW-1:0] lat;

  for (genvar g = 0; g < N_SW; g++) begin : g_sw
    logic [SYNC_W-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sh_q <= '0;
      else if (pwr_clr_i) sh_q <= '0;
      else                sh_q <= {sh_q[SYNC_W-2:0], sw_i[g]};
    end
    if (g == 0) begin : g_main
      assign lat[g] = sh_q[SYNC_W-1];
    end else begin : g_aux
      // single-switch variant: extra latches held in inserted state
      assign lat[g] = front_load_i | sh_q[SYNC_W-1];
    end
  end

  assign cart_ok_o = &lat;
endmodule

// File: rtl/dss_run_ctl.sv
module dss_run_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_clr_i,
  input  logic emerg_i,
  input  logic btn_i,
  input  logic cart_ok_i,
  input  logic hr_i,
  input  logic rot_i,
  input  logic brake_i,
  input  logic seq_done_i,
  input  logic stop_done_i,
  output logic run_o,
  output logic run_nxt_o,
  output logic stop_pend_o,
  output logic stop_cmpl_o
);
  logic run_q, stop_pend_q;
  logic force_off, start_ok, run_nxt, stop_cmpl;

  assign force_off = emerg_i | ~cart_ok_i;
  // restart guard: previous stop must be complete
  assign start_ok  = hr_i & ~rot_i & ~brake_i & ~stop_pend_q & ~seq_done_i;
  assign stop_cmpl = stop_pend_q & stop_done_i & hr_i;

  always_comb begin
    if (pwr_clr_i || force_off) run_nxt = 1'b0;
    else if (btn_i)             run_nxt = ~run_q & start_ok;
    else                        run_nxt = run_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (pwr_clr_i) begin
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
    end else begin
      run_q <= run_nxt;
      if (run_q && !run_nxt) stop_pend_q <= 1'b1;
      else if (stop_cmpl)    stop_pend_q <= 1'b0;
    end
  end

  assign run_o       = run_q;
  assign run_nxt_o   = run_nxt;
  assign stop_pend_o = stop_pend_q;
  assign stop_cmpl_o = stop_cmpl;

  // R2
  btn_stops_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_i && run_q |=> !run_q);
  // R3
  interlock_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && (!hr_i || rot_i || brake_i) |=> !run_q);
  // R5
  forced_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_clr_i || emerg_i || !cart_ok_i) |=> !run_q);
  // R9
  no_reentry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && (stop_pend_q || seq_done_i) |=> !run_q);
  // R8
  stop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !pwr_clr_i && (btn_i || emerg_i || !cart_ok_i) |=> stop_pend_q);
endmodule

// File: rtl/dss_phase_seq.sv
module dss_phase_seq
  import dss_pkg::*;
#(
  parameter int unsigned SPD_W     = 8,
  parameter int unsigned NOM_PCT   = 100,
  parameter int unsigned BOOST_PCT = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_clr_i,
  input  logic             run_q_i,
  input  logic             run_nxt_i,
  input  logic             stop_cmpl_i,
  input  logic             purge_done_i,
  input  logic             load_done_i,
  output logic             purge_o,
  output logic             load_o,
  output logic             seq_done_o,
  output logic             overspeed_o,
  output logic [SPD_W-1:0] speed_pct_o
);
  localparam int unsigned BoostSpd = NOM_PCT + (NOM_PCT * BOOST_PCT) / 100;
  localparam logic [SPD_W-1:0] NomW   = SPD_W'(NOM_PCT);
  localparam logic [SPD_W-1:0] BoostW = SPD_W'(BoostSpd);

  phase_e ph_q, ph_n;
  logic   sd_q;

  always_comb begin
    ph_n = ph_q;
    if (!run_nxt_i) ph_n = PH_IDLE;
    else begin
      unique case (ph_q)
        PH_IDLE:  if (run_q_i)      ph_n = PH_PURGE;
        PH_PURGE: if (purge_done_i) ph_n = PH_LOAD;
        PH_LOAD:  if (load_done_i)  ph_n = PH_READY;
        default:                    ph_n = PH_READY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE;
      sd_q <= 1'b0;
    end else if (pwr_clr_i) begin
      ph_q <= PH_IDLE;
      sd_q <= 1'b0;
    end else begin
      ph_q <= ph_n;
      // sequence-complete also marks a stop in progress; held until stop done
      if (stop_cmpl_i)                               sd_q <= 1'b0;
      else if (ph_q == PH_LOAD && ph_n == PH_READY)  sd_q <= 1'b1;
    end
  end

  assign purge_o     = (ph_q == PH_PURGE);
  assign load_o      = (ph_q == PH_LOAD);
  assign seq_done_o  = sd_q;
  assign overspeed_o = purge_o;
  assign speed_pct_o = !run_q_i ? '0 : (purge_o ? BoostW : NomW);

  // R6
  phase_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_LOAD) |=> (ph_q != PH_PURGE));
  // R6
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({purge_o, load_o}));
  // R7
  overspeed_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overspeed_o |-> run_q_i && speed_pct_o == BoostW);
  // R1
  pwr_clr_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_clr_i |=> ph_q == PH_IDLE && !sd_q);
  // R10
  purge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_PURGE) && !purge_done_i && run_nxt_i |=> (ph_q == PH_PURGE));
endmodule

// File: rtl/dss_startstop.sv
module dss_startstop #(
  parameter int unsigned SPD_W     = 8,
  parameter int unsigned NOM_PCT   = 100,
  parameter int unsigned BOOST_PCT = 10,
  parameter int unsigned SYNC_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_clr_i,
  input  logic             emerg_unload_i,
  input  logic             run_btn_i,
  input  logic             cart_sw_a_i,
  input  logic             cart_sw_b_i,
  input  logic             front_load_i,
  input  logic             heads_retracted_i,
  input  logic             disk_rotating_i,
  input  logic             brake_active_i,
  input  logic             purge_done_i,
  input  logic             load_done_i,
  input  logic             stop_done_i,
  output logic             run_o,
  output logic             purge_o,
  output logic             load_heads_o,
  output logic             seq_done_o,
  output logic             stop_pend_o,
  output logic             overspeed_o,
  output logic [SPD_W-1:0] speed_pct_o
);
  logic cart_ok, run_q, run_nxt, stop_cmpl, seq_done;

  dss_cart_latch #(.N_SW(2), .SYNC_W(SYNC_W)) u_cart (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_clr_i   (pwr_clr_i),
    .sw_i        ({cart_sw_b_i, cart_sw_a_i}),
    .front_load_i(front_load_i),
    .cart_ok_o   (cart_ok)
  );

  dss_run_ctl u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_clr_i  (pwr_clr_i),
    .emerg_i    (emerg_unload_i),
    .btn_i      (run_btn_i),
    .cart_ok_i  (cart_ok),
    .hr_i       (heads_retracted_i),
    .rot_i      (disk_rotating_i),
    .brake_i    (brake_active_i),
    .seq_done_i (seq_done),
    .stop_done_i(stop_done_i),
    .run_o      (run_q),
    .run_nxt_o  (run_nxt),
    .stop_pend_o(stop_pend_o),
    .stop_cmpl_o(stop_cmpl)
  );

  dss_phase_seq #(.SPD_W(SPD_W), .NOM_PCT(NOM_PCT), .BOOST_PCT(BOOST_PCT)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_clr_i   (pwr_clr_i),
    .run_q_i     (run_q),
    .run_nxt_i   (run_nxt),
    .stop_cmpl_i (stop_cmpl),
    .purge_done_i(purge_done_i),
    .load_done_i (load_done_i),
    .purge_o     (purge_o),
    .load_o      (load_heads_o),
    .seq_done_o  (seq_done),
    .overspeed_o (overspeed_o),
    .speed_pct_o (speed_pct_o)
  );

  assign run_o      = run_q;
  assign seq_done_o = seq_done;

  // R9
  flags_need_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done && !run_q && !pwr_clr_i && !stop_done_i |=> seq_done);
endmodule

// File: tb/dss_startstop_tb.sv
module dss_startstop_tb_top;
  localparam int CLK_NS = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_clr = 0, emerg = 0, btn = 0, sw_a = 0, sw_b = 0, front = 0;
  logic hr = 1, rot = 0, brk = 0, pdone = 0, ldone = 0, sdone = 0;
  logic run, purge, load, sdn, spend, ovs;
  logic [7:0] spd;

  int n_chk = 0, n_bad = 0;

  // reference model state
  bit m_run, m_sd, m_sp, sa1, sa2, sb1, sb2;
  int m_ph;

  always #(CLK_NS/2) clk = ~clk;

  dss_startstop dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_clr_i(pwr_clr), .emerg_unload_i(emerg),
    .run_btn_i(btn), .cart_sw_a_i(sw_a), .cart_sw_b_i(sw_b), .front_load_i(front),
    .heads_retracted_i(hr), .disk_rotating_i(rot), .brake_active_i(brk),
    .purge_done_i(pdone), .load_done_i(ldone), .stop_done_i(sdone),
    .run_o(run), .purge_o(purge), .load_heads_o(load), .seq_done_o(sdn),
    .stop_pend_o(spend), .overspeed_o(ovs), .speed_pct_o(spd)
  );

  function automatic int exp_speed();
    return !m_run ? 0 : (m_ph == 1 ? 110 : 100);
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_run = 0; m_sd = 0; m_sp = 0; m_ph = 0; sa1 = 0; sa2 = 0; sb1 = 0; sb2 = 0;
  endtask

  // one clock: compute model next state from current inputs, then compare
  task automatic step();
    bit cok, ok, rn, cmpl, sp_n, sd_n;
    int ph_n;
    if (pwr_clr) model_clear();
    else begin
      cok  = sa2 & (sb2 | front);
      ok   = hr & !rot & !brk & !m_sp & !m_sd;
      rn   = (!cok || emerg) ? 0 : (btn ? (!m_run & ok) : m_run);
      cmpl = m_sp & sdone & hr;
      sp_n = (m_run && !rn) ? 1 : (cmpl ? 0 : m_sp);
      if (!rn) ph_n = 0;
      else case (m_ph)
        0: ph_n = m_run ? 1 : 0;
        1: ph_n = pdone ? 2 : 1;
        2: ph_n = ldone ? 3 : 2;
        default: ph_n = 3;
      endcase
      sd_n = cmpl ? 0 : ((m_ph == 2 && ph_n == 3) ? 1 : m_sd);
      sa2 = sa1; sa1 = sw_a; sb2 = sb1; sb1 = sw_b;
      m_run = rn; m_sp = sp_n; m_ph = ph_n; m_sd = sd_n;
    end
    @(posedge clk);
    @(negedge clk);
    chk(run,   m_run,          "R3 run");
    chk(purge, m_ph == 1,      "R6 purge");
    chk(load,  m_ph == 2,      "R6 load");
    chk(sdn,   m_sd,           "R9 seq_done");
    chk(spend, m_sp,           "R8 stop_pend");
    chk(ovs,   m_ph == 1,      "R7 overspeed");
    chk(spd,   exp_speed(),    "R7 speed");
    btn = 0; pdone = 0; ldone = 0; sdone = 0; pwr_clr = 0;
  endtask

  task automatic do_pwr_clr();
    pwr_clr = 1; step();
  endtask

  task automatic settle_cart();
    sw_a = 1; sw_b = 1; repeat (3) step();
  endtask

  task automatic full_stop();
    hr = 1; sdone = 1; step();
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({run, purge, load, sdn, spend, ovs}, 0, "R1 flags after reset");
    chk(spd, 0, "R1 speed after reset");

    // normal start
    settle_cart();
    btn = 1; step();
    chk(run, 1, "R3 start accepted");
    chk(purge, 0, "R6 purge not same edge");
    ldone = 1; step();
    chk(purge, 1, "R6 purge after run");
    chk(spd, 110, "R7 purge speed");
    chk(load, 0, "R10 stray load_done ignored");
    pdone = 1; step();
    chk(load, 1, "R6 load after purge");
    chk(spd, 100, "R7 nominal speed");
    ldone = 1; step();
    chk(sdn, 1, "R6 seq_done");

    // stop then attempted restart
    hr = 0; rot = 1; brk = 1; btn = 1; step();
    chk(run, 0, "R2 stop ignores interlocks");
    chk(spend, 1, "R8 stop pending");
    chk(sdn, 1, "R9 seq_done held during stop");
    hr = 1; rot = 0; brk = 0; btn = 1; step();
    chk(run, 0, "R9 restart before stop done");
    hr = 0; sdone = 1; step();
    chk(spend, 1, "R9 stop_done needs heads retracted");
    full_stop();
    chk(spend, 0, "R9 stop pending cleared");
    chk(sdn, 0, "R9 seq_done cleared");
    btn = 1; step();
    chk(run, 1, "R9 restart after stop");

    // stop mid-purge
    step();
    chk(purge, 1, "R6 purge again");
    btn = 1; step();
    chk(purge, 0, "R8 purge dropped");
    chk(spend, 1, "R8 stop pending mid-sequence");
    chk(spd, 0, "R7 speed zero when stopped");
    full_stop();

    // blocked start per interlock
    hr = 0; btn = 1; step(); chk(run, 0, "R3 blocked heads out");
    hr = 1; rot = 1; btn = 1; step(); chk(run, 0, "R3 blocked rotating");
    rot = 0; brk = 1; btn = 1; step(); chk(run, 0, "R3 blocked brake");
    brk = 0;

    // cartridge removal during run
    btn = 1; step(); chk(run, 1, "R4 run with cartridge");
    sw_b = 0; step(); step();
    chk(run, 1, "R4 run until sync passes");
    step();
    chk(run, 0, "R4 removal forces off");
    full_stop();
    btn = 1; step(); chk(run, 0, "R4 no start without cartridge");
    front = 1; btn = 1; step(); chk(run, 1, "R4 front-load ignores switch B");

    // emergency unload
    emerg = 1; step(); emerg = 0;
    chk(run, 0, "R5 emergency forces off");
    chk(spend, 1, "R5 state kept on emergency");
    full_stop();
    btn = 1; step(); chk(run, 1, "R5 restart after unload");
    do_pwr_clr();
    chk({run, purge, load, sdn, spend}, 0, "R1 power clear");
    front = 0; sw_b = 1;

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      pwr_clr = ($urandom_range(0, 199) == 0);
      emerg   = ($urandom_range(0, 63) == 0);
      btn     = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 39) == 0) sw_a = ~sw_a;
      if ($urandom_range(0, 39) == 0) sw_b = ~sw_b;
      if ($urandom_range(0, 299) == 0) front = ~front;
      hr    = ($urandom_range(0, 3) != 0);
      rot   = ($urandom_range(0, 3) == 0);
      brk   = ($urandom_range(0, 7) == 0);
      pdone = ($urandom_range(0, 3) == 0);
      ldone = ($urandom_range(0, 3) == 0);
      sdone = ($urandom_range(0, 5) == 0);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial void'($urandom(32'h5eed_d15c));
endmodule